// File: doc/BRIEF.md
# Banked GPIO Controller with Edge Capture

This block is a register-mapped general-purpose I/O controller for a pin count that is a multiple of 32. Software reaches it through a single-cycle 32-bit register port. The registers are grouped by function, and each function occupies a bank of consecutive words. Through these banks software reads the synchronized pin levels, chooses the direction of each pin, and drives output values through write-one set and clear words. It can also arm rising and falling edge capture per pin, read and acknowledge the captured edges, and hand individual pins over to an alternate function.

Every pin input passes through a multi-stage synchronizer. An edge is seen when the synchronized value differs from its value one cycle earlier. An edge whose direction is armed for that pin sets a sticky status bit, and a single interrupt line stays high while any status bit is set. Pins given to an alternate function have their GPIO output enable suppressed. Their 2-bit selector is presented on a port for the pad multiplexer outside this block.

Top module: `pin_bank_ctrl`

## Requirements
- R1: With NREG = NPINS/32, the banks appear in this order: level (0), direction (1), set (2), clear (3), rise arm (4), fall arm (5), edge status (6), alternate function (7). Word i of bank g sits at byte address g*NREG*4 + i*4, and pin p is bit p%32 of word p/32. The alternate-function bank is 2*NREG words long.
- R2: After reset, direction, output value, both arm banks, edge status and alternate function are all zero. As a result pin_out, pin_oe, alt_sel and irq are all zero.
- R3: A read of the level bank returns pin_in after the synchronizer (two clock edges by default). Writes to the level bank change nothing.
- R4: A direction bit of 1 makes the pin an output (pin_oe high), and 0 makes it an input. The direction bank is read and written as whole words.
- R5: A 1 written to a set-bank bit drives that pin_out bit high, and a 1 written to a clear-bank bit drives it low. Zero bits leave pin_out unchanged, and both banks read as zero.
- R6: A status bit is set one cycle after its synchronized pin rises with its rise-arm bit set, or falls with its fall-arm bit set. An edge on a direction that is not armed sets nothing.
- R7: Writing 1 to a status bit clears it, and zero bits leave status untouched. If an armed edge is detected in the same cycle as the clearing write, the bit stays set.
- R8: Pin p's alternate-function field is the 2 bits starting at bit (p%16)*2 of alternate-function word p/16, and it appears on alt_sel[2p+1:2p]. 00 means plain GPIO. Any other value forces pin_oe[p] low whatever the direction bit holds.
- R9: irq is high exactly while at least one status bit is set.
- R10: Addresses at or beyond byte 9*NREG*4 read as zero, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_en | input | 1 | Register access strobe |
| reg_we | input | 1 | 1 = write, 0 = read |
| reg_addr | input | ADDR_W | Byte address (low two bits ignored) |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid in the same cycle as a read strobe |
| pin_in | input | NPINS | Asynchronous pin levels |
| pin_out | output | NPINS | GPIO output values |
| pin_oe | output | NPINS | GPIO output enables |
| alt_sel | output | 2*NPINS | Alternate-function selector, 2 bits per pin |
| irq | output | 1 | Combined edge interrupt |

## Verification
The hardest case to reach from the ports is an armed edge that shows up in exactly the cycle in which software writes 1 to clear the same status bit. That cycle depends on the depth of the synchronizer and on the edge-compare register. The stimulus first leaves the bit set and returns the pin to low. It then raises the pin on a falling clock edge, waits two full cycles so that the compare sees the new level, and presents the clearing write for the next rising edge. A later read must still find the bit set.

// File: rtl/pin_bank_pkg.sv
package pin_bank_pkg;
   localparam int WORD_W       = 32;
   localparam int ALT_PER_WORD = 16;
   localparam int NUM_BANKS    = 8;

   typedef enum logic [2:0] {
      BANK_LEVEL = 3'd0,
      BANK_DIR   = 3'd1,
      BANK_SET   = 3'd2,
      BANK_CLR   = 3'd3,
      BANK_RISE  = 3'd4,
      BANK_FALL  = 3'd5,
      BANK_STAT  = 3'd6,
      BANK_ALT   = 3'd7
   } bank_e;
endpackage

// File: rtl/bank_addr_decode.sv
module bank_addr_decode
   import pin_bank_pkg::*;
#(
   parameter int NREG   = 2,
   parameter int ADDR_W = 8,
   localparam int IDX_W = (2 * NREG > 1) ? $clog2(2 * NREG) : 1
) (
   input  logic [ADDR_W-1:0] addr,
   output bank_e             bank,
   output logic [IDX_W-1:0]  word,
   output logic              in_map
);
   localparam int ALT_FIRST = 7 * NREG;
   localparam int MAP_WORDS = 9 * NREG;

   logic unused_lsb;
   assign unused_lsb = ^addr[1:0];

   always_comb begin
      int unsigned wi;
      wi     = 32'(addr[ADDR_W-1:2]);
      in_map = (wi < MAP_WORDS);
      if (wi >= ALT_FIRST) begin
         bank = BANK_ALT;
         word = IDX_W'(wi - ALT_FIRST);
      end else begin
         bank = bank_e'(3'(wi / NREG));
         word = IDX_W'(wi % NREG);
      end
   end
endmodule

// File: rtl/pin_sync_edge.sv
module pin_sync_edge #(
   parameter int NPINS  = 64,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NPINS-1:0] pin_async,
   output logic [NPINS-1:0] level,
   output logic [NPINS-1:0] rise,
   output logic [NPINS-1:0] fall
);
   logic [NPINS-1:0] stage_q [STAGES];
   logic [NPINS-1:0] prev_q;

   generate
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n)
               if (!rst_n) stage_q[0] <= '0;
               else        stage_q[0] <= pin_async;
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n)
               if (!rst_n) stage_q[s] <= '0;
               else        stage_q[s] <= stage_q[s-1];
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) prev_q <= '0;
      else        prev_q <= stage_q[STAGES-1];

   assign level = stage_q[STAGES-1];
   assign rise  = stage_q[STAGES-1] & ~prev_q;
   assign fall  = ~stage_q[STAGES-1] & prev_q;
endmodule

// File: rtl/edge_status_bank.sv
module edge_status_bank #(
   parameter int NPINS = 64
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NPINS-1:0] rise,
   input  logic [NPINS-1:0] fall,
   input  logic [NPINS-1:0] rise_arm,
   input  logic [NPINS-1:0] fall_arm,
   input  logic [NPINS-1:0] ack,
   output logic [NPINS-1:0] status
);
   logic [NPINS-1:0] hit;

   assign hit = (rise & rise_arm) | (fall & fall_arm);

   // a fresh edge outranks an acknowledge in the same cycle
   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) status <= '0;
      else        status <= (status & ~ack) | hit;

   p_ack_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((status & $past(ack & ~hit)) == '0));

   p_edge_kept_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (|hit) |=> ((status & $past(hit)) == $past(hit)));
endmodule

// File: rtl/pin_bank_ctrl.sv
module pin_bank_ctrl
   import pin_bank_pkg::*;
#(
   parameter int NPINS       = 64,
   parameter int ADDR_W      = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               reg_en,
   input  logic               reg_we,
   input  logic [ADDR_W-1:0]  reg_addr,
   input  logic [31:0]        reg_wdata,
   output logic [31:0]        reg_rdata,
   input  logic [NPINS-1:0]   pin_in,
   output logic [NPINS-1:0]   pin_out,
   output logic [NPINS-1:0]   pin_oe,
   output logic [2*NPINS-1:0] alt_sel,
   output logic               irq
);
   localparam int NREG   = NPINS / WORD_W;
   localparam int NALT   = 2 * NREG;
   localparam int IDX_W  = (NALT > 1) ? $clog2(NALT) : 1;
   localparam int MAP_BY = 9 * NREG * 4;

   generate
      if (NPINS <= 0 || (NPINS % WORD_W) != 0) begin : g_bad_pins
         $error("NPINS must be a positive multiple of 32");
      end
      if (MAP_BY > (1 << ADDR_W)) begin : g_bad_addr
         $error("ADDR_W too narrow for the register map");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
   endgenerate

   bank_e              bank;
   logic [IDX_W-1:0]   word;
   logic               in_map, wr, rd;
   logic [NPINS-1:0]   lvl, rise, fall, status;
   logic [NPINS-1:0]   dir_q, dir_d, outv_q, outv_d;
   logic [NPINS-1:0]   rarm_q, rarm_d, farm_q, farm_d;
   logic [NPINS-1:0]   set_vec, clr_vec, ack_vec, alt_act;
   logic [2*NPINS-1:0] alt_q, alt_d;

   bank_addr_decode #(.NREG(NREG), .ADDR_W(ADDR_W)) i_dec (
      .addr(reg_addr), .bank(bank), .word(word), .in_map(in_map)
   );

   pin_sync_edge #(.NPINS(NPINS), .STAGES(SYNC_STAGES)) i_sync (
      .clk(clk), .rst_n(rst_n), .pin_async(pin_in),
      .level(lvl), .rise(rise), .fall(fall)
   );

   edge_status_bank #(.NPINS(NPINS)) i_stat (
      .clk(clk), .rst_n(rst_n), .rise(rise), .fall(fall),
      .rise_arm(rarm_q), .fall_arm(farm_q), .ack(ack_vec), .status(status)
   );

   assign wr = reg_en & reg_we & in_map;
   assign rd = reg_en & ~reg_we & in_map;

   always_comb begin
      dir_d   = dir_q;
      rarm_d  = rarm_q;
      farm_d  = farm_q;
      alt_d   = alt_q;
      set_vec = '0;
      clr_vec = '0;
      ack_vec = '0;
      for (int w = 0; w < NREG; w++) begin
         if (wr && word == IDX_W'(w)) begin
            case (bank)
               BANK_DIR:  dir_d[w*WORD_W +: WORD_W]   = reg_wdata;
               BANK_SET:  set_vec[w*WORD_W +: WORD_W] = reg_wdata;
               BANK_CLR:  clr_vec[w*WORD_W +: WORD_W] = reg_wdata;
               BANK_RISE: rarm_d[w*WORD_W +: WORD_W]  = reg_wdata;
               BANK_FALL: farm_d[w*WORD_W +: WORD_W]  = reg_wdata;
               BANK_STAT: ack_vec[w*WORD_W +: WORD_W] = reg_wdata;
               default: ;
            endcase
         end
      end
      for (int w = 0; w < NALT; w++) begin
         if (wr && bank == BANK_ALT && word == IDX_W'(w))
            alt_d[w*WORD_W +: WORD_W] = reg_wdata;
      end
      outv_d = (outv_q | set_vec) & ~clr_vec;
   end

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
         dir_q  <= '0;
         outv_q <= '0;
         rarm_q <= '0;
         farm_q <= '0;
         alt_q  <= '0;
      end else begin
         dir_q  <= dir_d;
         outv_q <= outv_d;
         rarm_q <= rarm_d;
         farm_q <= farm_d;
         alt_q  <= alt_d;
      end

   always_comb begin
      reg_rdata = '0;
      for (int w = 0; w < NREG; w++) begin
         if (rd && word == IDX_W'(w)) begin
            case (bank)
               BANK_LEVEL: reg_rdata = lvl[w*WORD_W +: WORD_W];
               BANK_DIR:   reg_rdata = dir_q[w*WORD_W +: WORD_W];
               BANK_RISE:  reg_rdata = rarm_q[w*WORD_W +: WORD_W];
               BANK_FALL:  reg_rdata = farm_q[w*WORD_W +: WORD_W];
               BANK_STAT:  reg_rdata = status[w*WORD_W +: WORD_W];
               default: ;
            endcase
         end
      end
      for (int w = 0; w < NALT; w++) begin
         if (rd && bank == BANK_ALT && word == IDX_W'(w))
            reg_rdata = alt_q[w*WORD_W +: WORD_W];
      end
   end

   generate
      for (genvar p = 0; p < NPINS; p++) begin : g_pin
         assign alt_act[p] = |alt_q[2*p +: 2];

         p_alt_blocks_oe_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (alt_sel[2*p +: 2] != 2'b00) |-> !pin_oe[p]);
      end
   endgenerate

   assign pin_out = outv_q;
   assign pin_oe  = dir_q & ~alt_act;
   assign alt_sel = alt_q;
   assign irq     = |status;

   p_set_drives_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (set_vec != '0) |=> ((pin_out & $past(set_vec)) == $past(set_vec)));

   p_clr_drives_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_vec != '0) |=> ((pin_out & $past(clr_vec)) == '0));

   p_level_ro_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && bank == BANK_LEVEL) |=>
         ($stable(pin_out) && $stable(pin_oe) && $stable(alt_sel)));

   p_irq_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (irq && ack_vec == '0) |=> irq);

   p_oor_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_en && reg_we && !in_map) |=>
         ($stable(pin_out) && $stable(pin_oe) && $stable(alt_sel)));

   p_oor_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_en && !in_map) |-> (reg_rdata == '0));
endmodule

// File: tb/test_pin_bank_ctrl.sv
`timescale 1ns/1ps
module test_pin_bank_ctrl;
   localparam int NPINS  = 64;
   localparam int ADDR_W = 8;

   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic               reg_en = 1'b0, reg_we = 1'b0;
   logic [ADDR_W-1:0]  reg_addr = '0;
   logic [31:0]        reg_wdata = '0;
   logic [31:0]        reg_rdata;
   logic [NPINS-1:0]   pin_in = '0;
   logic [NPINS-1:0]   pin_out, pin_oe;
   logic [2*NPINS-1:0] alt_sel;
   logic               irq;

   int n_cmp = 0, n_bad = 0;

   always #4 clk = ~clk;

   pin_bank_ctrl #(.NPINS(NPINS), .ADDR_W(ADDR_W), .SYNC_STAGES(2)) i_pin_bank_ctrl (
      .clk(clk), .rst_n(rst_n), .reg_en(reg_en), .reg_we(reg_we),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
      .alt_sel(alt_sel), .irq(irq)
   );

   typedef struct packed {
      logic [7:0]  waddr;
      logic [31:0] wdata;
      logic [7:0]  raddr;
      logic [31:0] rexp;
      logic [3:0]  req;
   } vec_t;

   localparam int NVEC = 10;
   localparam vec_t VECS [NVEC] = '{
      '{8'h08, 32'hA5A50F0F, 8'h08, 32'hA5A50F0F, 4'd4},  // R4 dir word 0
      '{8'h0C, 32'h12345678, 8'h0C, 32'h12345678, 4'd1},  // R1 dir word 1
      '{8'h10, 32'hFFFF0000, 8'h10, 32'h00000000, 4'd5},  // R5 set reads 0
      '{8'h18, 32'h0F000000, 8'h18, 32'h00000000, 4'd5},  // R5 clear reads 0
      '{8'h24, 32'h80000001, 8'h24, 32'h80000001, 4'd6},  // R6 rise arm word 1
      '{8'h28, 32'h000000FF, 8'h28, 32'h000000FF, 4'd6},  // R6 fall arm word 0
      '{8'h38, 32'h0000000C, 8'h38, 32'h0000000C, 4'd8},  // R8 pin 1 alt = 3
      '{8'h00, 32'hFFFFFFFF, 8'h00, 32'h00000000, 4'd3},  // R3 level ignores write
      '{8'h48, 32'hDEADBEEF, 8'h48, 32'h00000000, 4'd10}, // R10 beyond map
      '{8'h3C, 32'h0C000000, 8'h3C, 32'h0C000000, 4'd1}   // R1 alt word 1, pin 29
   };

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic reg_write(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_en = 1'b1; reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_en = 1'b0; reg_we = 1'b0;
   endtask

   task automatic reg_read(input logic [7:0] a, output logic [31:0] d);
      @(negedge clk);
      reg_en = 1'b1; reg_we = 1'b0; reg_addr = a;
      #1 d = reg_rdata;
      reg_en = 1'b0;
   endtask

   task automatic settle();
      repeat (4) @(negedge clk);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog (all requirements): actual running expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      logic [31:0] rv;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R2 reset state
      check("R2 pin_out", pin_out[31:0] | pin_out[63:32], 32'h0);
      check("R2 pin_oe",  pin_oe[31:0] | pin_oe[63:32], 32'h0);
      check("R2 irq",     {31'b0, irq}, 32'h0);
      reg_read(8'h0C, rv); check("R2 dir word 1", rv, 32'h0);
      reg_read(8'h3C, rv); check("R2 alt word 1", rv, 32'h0);
      reg_read(8'h34, rv); check("R2 status word 1", rv, 32'h0);

      for (int i = 0; i < NVEC; i++) begin
         reg_write(VECS[i].waddr, VECS[i].wdata);
         reg_read(VECS[i].raddr, rv);
         check($sformatf("R%0d vector %0d", VECS[i].req, i), rv, VECS[i].rexp);
      end

      @(negedge clk);
      check("R5 pin_out low word", pin_out[31:0], 32'hF0FF0000);
      check("R5 pin_out high word", pin_out[63:32], 32'h0);
      check("R8 pin_oe low word", pin_oe[31:0], 32'h85A50F0D);
      check("R4 pin_oe high word", pin_oe[63:32], 32'h12345678);
      check("R8 alt_sel pin 1 and 29", {28'b0, alt_sel[3:2], alt_sel[59:58]}, 32'hF);

      // R6 armed rising edge on pin 32
      @(negedge clk); pin_in[32] = 1'b1; settle();
      reg_read(8'h34, rv); check("R6 rise latched", rv, 32'h1);
      check("R9 irq set", {31'b0, irq}, 32'h1);

      // R6 unarmed pin 33; R3 level readback
      @(negedge clk); pin_in[33] = 1'b1; settle();
      reg_read(8'h34, rv); check("R6 unarmed rise", rv, 32'h1);
      reg_read(8'h04, rv); check("R3 level word 1", rv, 32'h3);

      // R6 pin 0: rising not armed, falling armed
      @(negedge clk); pin_in[0] = 1'b1; settle();
      reg_read(8'h30, rv); check("R6 rise unarmed pin 0", rv, 32'h0);
      @(negedge clk); pin_in[0] = 1'b0; settle();
      reg_read(8'h30, rv); check("R6 fall latched", rv, 32'h1);

      // R7 write-one-to-clear
      reg_write(8'h34, 32'h1);
      reg_read(8'h34, rv); check("R7 cleared", rv, 32'h0);
      reg_read(8'h30, rv); check("R7 other word kept", rv, 32'h1);
      check("R9 irq still set", {31'b0, irq}, 32'h1);
      reg_write(8'h30, 32'hFFFFFFFF);
      reg_read(8'h30, rv); check("R7 cleared word 0", rv, 32'h0);
      check("R9 irq dropped", {31'b0, irq}, 32'h0);

      // R7 edge in the same cycle as the clearing write
      @(negedge clk); pin_in[32] = 1'b0; settle();
      @(negedge clk); pin_in[32] = 1'b1; settle();
      @(negedge clk); pin_in[32] = 1'b0; settle();
      reg_read(8'h34, rv); check("R7 setup bit set", rv, 32'h1);
      @(negedge clk); pin_in[32] = 1'b1;
      @(negedge clk);
      @(negedge clk);
      reg_en = 1'b1; reg_we = 1'b1; reg_addr = 8'h34; reg_wdata = 32'h1;
      @(negedge clk);
      reg_en = 1'b0; reg_we = 1'b0;
      reg_read(8'h34, rv); check("R7 coincident edge kept", rv, 32'h1);

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule